// File: doc/BRIEF.md
# Bridge Interrupt Line Aggregator

This block gathers eleven level-sensitive interrupt lines from devices behind a bus bridge and turns them into a single upstream message interrupt. Each line is brought into the clock domain through a two-flop synchronizer. Any change of level on an implemented line, rising or falling, is latched into a pending register. When a change arrives on a line whose enable bit is set, the block raises a posted write. The write carries a programmed data value to a programmed host address, and it is held on a valid/ready port until the host bus takes it.

Software reaches the block through a small register port. One register holds the target word, with the address in the upper bits and the data value in the low five bits. The other registers are two pending views, both cleared when read; an enable mask; and a live-level view of the synchronized lines. Once a message has been sent, the block sends no further one until software reads a pending view. This keeps a chattering line from producing a stream of writes. A driver can emulate level-triggered behaviour in two ways: it can check the live view after it unmasks a line, or it can write the pending offset, which forces a fresh message.

Line use: bits 0 to 5 carry the six PCI interrupt lines, bit 6 the external bus interrupt and bit 10 the serial port. Bits 7, 8 and 9 have no device assigned. Bit 9 has no pending storage.

Top module: `irq_line_aggregator`

## Requirements
- R1: A read of offset 0x028 returns the synchronized level of every line in bits 10:0, whatever the mask. Upper bits read zero. A line change appears there two clock edges after it is presented. The read leaves pending state untouched.
- R2: A change in either direction on line i sets pending bit i when bit i of 0x5FF is set. Bit 9 never becomes pending, and a change on it never causes a message.
- R3: A read of offset 0x00C returns the pending bits and clears them in the same access. A change detected in that same cycle stays pending.
- R4: A read of offset 0x01C returns the pending bits ANDed with the enable mask, and clears all pending bits.
- R5: A message is raised only by a change on a line whose enable bit (offset 0x018, bits 10:0) is set. A line that is already high when it is enabled raises nothing.
- R6: The message address is the target word at offset 0x004 with bits 4:0 cleared. The message data is bits 4:0 of that word, zero-extended.
- R7: While msgValid is high and msgReady is low, msgValid, msgAddr and msgData hold their values.
- R8: After a message is raised, enabled changes raise no further message until offset 0x00C or 0x01C has been read. A change in the cycle of such a read does raise one.
- R9: A write to offset 0x00C raises a message on the next clock edge, whatever the mask or the read state, provided the message port is free or its message is being accepted.
- R10: After reset the target, mask and pending registers are zero and msgValid is low.
- R11: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 11 | Asynchronous interrupt lines |
| regEn | input | 1 | Register access strobe, one cycle per access |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| msgValid | output | 1 | Message write pending on the host port |
| msgReady | input | 1 | Host port accepts the message |
| msgAddr | output | 32 | Message target address |
| msgData | output | 32 | Message data word |

## Verification
The assertions assume that a register access lasts exactly one cycle. They also assume that the host does not depend on msgValid falling without msgReady. The check that a second back-to-back pending read returns zero holds only when the lines have been quiet for at least four edges, so that no change is still in the synchronizer. The checker counts quiet cycles and does not rely on the stimulus for this. The bench drives the lines only at falling edges and issues every access as a one-cycle pulse. A deterministic shift-register pattern mixes line toggles, reads of every offset, retrigger writes and a randomly stalling msgReady.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_TARGET = 12'h004;
  localparam logic [REG_AW-1:0] OFF_PEND   = 12'h00C;
  localparam logic [REG_AW-1:0] OFF_MASK   = 12'h018;
  localparam logic [REG_AW-1:0] OFF_PEEK   = 12'h01C;
  localparam logic [REG_AW-1:0] OFF_LIVE   = 12'h028;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TARGET,
    SEL_PEND,
    SEL_MASK,
    SEL_PEEK,
    SEL_LIVE
  } rdSel_e;

  typedef struct packed {
    logic   wrTarget;
    logic   wrMask;
    logic   clrPend;
    logic   loadMsg;
    rdSel_e rdSel;
  } aggStrobe_t;

endpackage

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int                   NUM_LINES     = 11,
  parameter logic [NUM_LINES-1:0] IMPL_MASK     = 11'h5FF,
  parameter int                   DATA_W        = 32,
  parameter int                   MSG_DATA_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [DATA_W-1:0]    regWdata,
  input  aggStrobe_t           strobe,
  output logic                 enabledEvent,
  output logic [DATA_W-1:0]    regRdata,
  output logic [DATA_W-1:0]    msgAddr,
  output logic [DATA_W-1:0]    msgData
);

  localparam int PAD_W = DATA_W - NUM_LINES;
  localparam int ADDR_KEEP = DATA_W - MSG_DATA_BITS;

  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_LINES-1:0] prevLvl;
  logic [NUM_LINES-1:0] pendReg;
  logic [NUM_LINES-1:0] maskReg;
  logic [NUM_LINES-1:0] lineChange;
  logic [DATA_W-1:0]    targetReg;
  logic [DATA_W-1:0]    msgAddrReg;
  logic [DATA_W-1:0]    msgDataReg;

  // per-line synchronizer and change detector; unimplemented bits never pend
  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[i]   <= 1'b0;
        syncB[i]   <= 1'b0;
        prevLvl[i] <= 1'b0;
      end else begin
        syncA[i]   <= irqLines[i];
        syncB[i]   <= syncA[i];
        prevLvl[i] <= syncB[i];
      end
    end

    if (IMPL_MASK[i]) begin : gImpl
      assign lineChange[i] = syncB[i] ^ prevLvl[i];
      always_ff @(posedge clk) begin
        if (!rstN)
          pendReg[i] <= 1'b0;
        else
          pendReg[i] <= (pendReg[i] & ~strobe.clrPend) | lineChange[i];
      end
    end else begin : gHole
      assign lineChange[i] = 1'b0;
      always_ff @(posedge clk) pendReg[i] <= 1'b0;
    end
  end

  assign enabledEvent = |(lineChange & maskReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      targetReg <= '0;
    end else begin
      if (strobe.wrMask)   maskReg   <= regWdata[NUM_LINES-1:0];
      if (strobe.wrTarget) targetReg <= regWdata;
    end
  end

  // message fields are captured once and held until the host takes them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddrReg <= '0;
      msgDataReg <= '0;
    end else if (strobe.loadMsg) begin
      msgAddrReg <= {targetReg[DATA_W-1:MSG_DATA_BITS], {MSG_DATA_BITS{1'b0}}};
      msgDataReg <= {{ADDR_KEEP{1'b0}}, targetReg[MSG_DATA_BITS-1:0]};
    end
  end

  assign msgAddr = msgAddrReg;
  assign msgData = msgDataReg;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_TARGET: regRdata = targetReg;
      SEL_PEND:   regRdata = {{PAD_W{1'b0}}, pendReg};
      SEL_MASK:   regRdata = {{PAD_W{1'b0}}, maskReg};
      SEL_PEEK:   regRdata = {{PAD_W{1'b0}}, pendReg & maskReg};
      SEL_LIVE:   regRdata = {{PAD_W{1'b0}}, syncB};
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              enabledEvent,
  input  logic              msgReady,
  output logic              msgValid,
  output aggStrobe_t        strobe
);

  logic armed;
  logic validReg;
  logic rdAccess;
  logic wrAccess;
  logic pendRead;
  logic swTrigger;
  logic fireMsg;
  logic portFree;

  assign rdAccess  = regEn & ~regWr;
  assign wrAccess  = regEn &  regWr;
  assign pendRead  = rdAccess & ((regAddr == OFF_PEND) | (regAddr == OFF_PEEK));
  assign swTrigger = wrAccess & (regAddr == OFF_PEND);
  assign fireMsg   = (enabledEvent & (armed | pendRead)) | swTrigger;
  assign portFree  = ~validReg | msgReady;

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = SEL_NONE;
    strobe.wrTarget = wrAccess & (regAddr == OFF_TARGET);
    strobe.wrMask   = wrAccess & (regAddr == OFF_MASK);
    strobe.clrPend  = pendRead;
    strobe.loadMsg  = fireMsg & portFree;
    if (rdAccess) begin
      unique case (regAddr)
        OFF_TARGET: strobe.rdSel = SEL_TARGET;
        OFF_PEND:   strobe.rdSel = SEL_PEND;
        OFF_MASK:   strobe.rdSel = SEL_MASK;
        OFF_PEEK:   strobe.rdSel = SEL_PEEK;
        OFF_LIVE:   strobe.rdSel = SEL_LIVE;
        default:    strobe.rdSel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b1;
      validReg <= 1'b0;
    end else begin
      if (fireMsg)       armed <= 1'b0;
      else if (pendRead) armed <= 1'b1;

      if (fireMsg && portFree)      validReg <= 1'b1;
      else if (validReg && msgReady) validReg <= 1'b0;
    end
  end

  assign msgValid = validReg;

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
  import irq_agg_pkg::*;
#(
  parameter int                   NUM_LINES     = 11,
  parameter logic [NUM_LINES-1:0] IMPL_MASK     = 11'h5FF,
  parameter int                   DATA_W        = 32,
  parameter int                   MSG_DATA_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 regEn,
  input  logic                 regWr,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [DATA_W-1:0]    msgAddr,
  output logic [DATA_W-1:0]    msgData
);

  aggStrobe_t strobe;
  logic       enabledEvent;

  irq_agg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regEn        (regEn),
    .regWr        (regWr),
    .regAddr      (regAddr),
    .enabledEvent (enabledEvent),
    .msgReady     (msgReady),
    .msgValid     (msgValid),
    .strobe       (strobe)
  );

  irq_agg_datapath #(
    .NUM_LINES     (NUM_LINES),
    .IMPL_MASK     (IMPL_MASK),
    .DATA_W        (DATA_W),
    .MSG_DATA_BITS (MSG_DATA_BITS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .irqLines     (irqLines),
    .regWdata     (regWdata),
    .strobe       (strobe),
    .enabledEvent (enabledEvent),
    .regRdata     (regRdata),
    .msgAddr      (msgAddr),
    .msgData      (msgData)
  );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 11,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqLines,
  input logic                 regEn,
  input logic                 regWr,
  input logic [REG_AW-1:0]    regAddr,
  input logic [DATA_W-1:0]    regRdata,
  input logic                 msgValid,
  input logic                 msgReady,
  input logic [DATA_W-1:0]    msgAddr,
  input logic [DATA_W-1:0]    msgData
);

  logic [NUM_LINES-1:0] lastLines;
  logic [2:0]           quietCnt;
  logic                 pendRd;
  logic                 liveRd;
  logic                 holeRd;

  assign pendRd = regEn & ~regWr & ((regAddr == OFF_PEND) | (regAddr == OFF_PEEK));
  assign liveRd = regEn & ~regWr & (regAddr == OFF_LIVE);
  assign holeRd = regEn & ~regWr & (regAddr != OFF_TARGET) & (regAddr != OFF_PEND) &
                  (regAddr != OFF_MASK) & (regAddr != OFF_PEEK) & (regAddr != OFF_LIVE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLines <= '0;
      quietCnt  <= '0;
    end else begin
      lastLines <= irqLines;
      if (irqLines != lastLines) quietCnt <= '0;
      else if (quietCnt != 3'd7) quietCnt <= quietCnt + 3'd1;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  p_hole_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && !regWr && regAddr == OFF_PEND) |-> (regRdata[9] == 1'b0));

  p_retrig_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && regWr && regAddr == OFF_PEND && (!msgValid || msgReady)) |=> msgValid);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pendRd && $past(pendRd) && quietCnt >= 3'd4) |-> (regRdata == '0));

  p_live_r1: assert property (@(posedge clk) disable iff (!rstN)
    liveRd |-> (regRdata[DATA_W-1:NUM_LINES] == '0));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rstN)
    holeRd |-> (regRdata == '0));

endmodule

bind irq_line_aggregator irq_agg_checker #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqLines (irqLines),
  .regEn    (regEn),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .msgAddr  (msgAddr),
  .msgData  (msgData)
);

// File: tb/tb_irq_line_aggregator.sv
module tb_irq_line_aggregator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] irqLines = '0;
  logic        regEn = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [31:0] msgAddr;
  logic [31:0] msgData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_line_aggregator dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines),
    .regEn(regEn), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  // behavioural reference state
  logic [10:0] mS1, mS2, mPrev, mPend, mEn;
  logic [31:0] mTgt, mAddr, mData;
  bit          mArmed, mValid;

  always @(posedge clk) begin
    logic [10:0] chg;
    bit rdP, go, free;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mPend = '0; mEn = '0;
      mTgt = '0; mAddr = '0; mData = '0; mArmed = 1; mValid = 0;
    end else begin
      chg  = (mS2 ^ mPrev) & 11'h5FF;
      rdP  = regEn && !regWr && (regAddr == 12'h00C || regAddr == 12'h01C);
      go   = ((chg & mEn) != 0 && (mArmed || rdP)) || (regEn && regWr && regAddr == 12'h00C);
      free = !mValid || msgReady;
      if (go && free) begin
        mValid = 1;
        mAddr  = mTgt & 32'hFFFF_FFE0;
        mData  = mTgt & 32'h0000_001F;
      end else if (mValid && msgReady) begin
        mValid = 0;
      end
      if (go) mArmed = 0; else if (rdP) mArmed = 1;
      mPend = (rdP ? 11'h0 : mPend) | chg;
      if (regEn && regWr && regAddr == 12'h004) mTgt = regWdata;
      if (regEn && regWr && regAddr == 12'h018) mEn = regWdata[10:0];
      mPrev = mS2; mS2 = mS1; mS1 = irqLines;
    end
  end

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h004: return mTgt;
      12'h00C: return {21'h0, mPend};
      12'h018: return {21'h0, mEn};
      12'h01C: return {21'h0, mPend & mEn};
      12'h028: return {21'h0, mS2};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      check("R5 msgValid vs model", {31'h0, msgValid}, {31'h0, mValid});
      if (mValid) begin
        check("R6 msgAddr vs model", msgAddr, mAddr);
        check("R6 msgData vs model", msgData, mData);
      end
      if (regEn && !regWr)
        check("R3 regRdata vs model", regRdata, modelRead(regAddr));
    end
  end

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regEn = 1; regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 0; regWr = 0;
  endtask

  task automatic regRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regEn = 1; regWr = 0; regAddr = a;
    #2 check(tag, regRdata, exp);
    @(negedge clk);
    regEn = 0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkValid(input bit exp, input string tag);
    @(negedge clk);
    #2 check(tag, {31'h0, msgValid}, {31'h0, exp});
  endtask

  task automatic acceptMsg();
    @(negedge clk);
    msgReady = 1;
    @(negedge clk);
    msgReady = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    waitCycles(3);
    @(negedge clk) rstN = 1;

    // R10: reset state
    checkValid(0, "R10 msgValid after reset");
    regRead(12'h004, 32'h0, "R10 target reset");
    regRead(12'h018, 32'h0, "R10 mask reset");
    regRead(12'h00C, 32'h0, "R10 pending reset");

    regWrite(12'h004, 32'h8000_1234);
    regWrite(12'h018, 32'h0000_07FF);

    // R5/R6: enabled rising change
    @(negedge clk) irqLines[0] = 1;
    waitCycles(4);
    checkValid(1, "R5 message on enabled change");
    check("R6 address", msgAddr, 32'h8000_1220);
    check("R6 data", msgData, 32'h0000_0014);
    waitCycles(4);
    checkValid(1, "R7 held while stalled");
    check("R7 address held", msgAddr, 32'h8000_1220);
    acceptMsg();
    checkValid(0, "R7 dropped after accept");

    // R8: no new message until pending read
    @(negedge clk) irqLines[1] = 1;
    waitCycles(5);
    checkValid(0, "R8 suppressed before read");
    regRead(12'h00C, 32'h0000_0003, "R3 pending read");
    regRead(12'h00C, 32'h0000_0000, "R3 pending cleared");

    // R2: unimplemented bit 9
    @(negedge clk) irqLines[9] = 1;
    waitCycles(5);
    checkValid(0, "R2 bit9 no message");
    regRead(12'h028, 32'h0000_0203, "R1 live level");
    regRead(12'h00C, 32'h0000_0000, "R2 bit9 not pending");

    // R4/R5: masked line
    regWrite(12'h018, 32'h0000_0001);
    @(negedge clk) irqLines[2] = 1;
    waitCycles(5);
    checkValid(0, "R5 masked change silent");
    regRead(12'h01C, 32'h0000_0000, "R4 peek masked");
    regRead(12'h00C, 32'h0000_0000, "R4 peek cleared pending");

    // R5: line already high when enabled
    regWrite(12'h018, 32'h0000_0005);
    waitCycles(5);
    checkValid(0, "R5 unmask of high line silent");

    // R1: live read leaves pending alone
    @(negedge clk) irqLines[3] = 1;
    waitCycles(5);
    regRead(12'h028, 32'h0000_020F, "R1 live with masked lines");
    regRead(12'h00C, 32'h0000_0008, "R1 live read kept pending");

    // R2: falling change
    @(negedge clk) irqLines[0] = 0;
    waitCycles(4);
    checkValid(1, "R2 falling change message");
    acceptMsg();
    checkValid(0, "R2 accepted");

    // R9: software retrigger
    regWrite(12'h00C, 32'h0);
    #2 check("R9 retrigger", {31'h0, msgValid}, 32'h1);
    acceptMsg();

    // R11: unmapped offsets
    regRead(12'h100, 32'h0, "R11 unmapped read");
    regWrite(12'h100, 32'hFFFF_FFFF);
    regRead(12'h004, 32'h8000_1234, "R11 write ignored target");
    regRead(12'h018, 32'h0000_0005, "R11 write ignored mask");

    // mixed traffic checked against the model every cycle
    regWrite(12'h018, 32'h0000_07FF);
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      msgReady = lfsr[3] & lfsr[7];
      if (lfsr[12:10] == 3'd0) irqLines[lfsr[17:14] % 11] = ~irqLines[lfsr[17:14] % 11];
      regEn = 0; regWr = 0;
      if (lfsr[22:20] == 3'd1) begin
        regEn = 1;
        regWr = (lfsr[25:23] == 3'd0);
        case (lfsr[28:26])
          3'd0: regAddr = 12'h004;
          3'd1, 3'd2: regAddr = 12'h00C;
          3'd3: regAddr = 12'h018;
          3'd4: regAddr = 12'h01C;
          3'd5: regAddr = 12'h028;
          default: regAddr = 12'h040;
        endcase
        regWdata = (regAddr == 12'h018) ? {21'h0, lfsr[10:0] | 11'h401} : lfsr;
      end
    end
    @(negedge clk);
    regEn = 0; regWr = 0; msgReady = 0;
    waitCycles(4);
    finishRun();
  end

endmodule